// File: doc/BRIEF.md
# Crypto Event Interrupt and DMA Request Router

This block sits beside a cipher engine and turns the engine's four event conditions into one interrupt line and four DMA request lines. The four conditions are: the engine can accept a new context, the input buffer can take data, an output block is ready, and a result context (tag and/or IV) is ready. A 32-bit word-addressed register port gives software a live view of the events, an interrupt enable word with the same bit layout, and a configuration word that holds one enable per DMA request.

The configuration word also has a fold option. When it is set, the result-context event is carried on the output-data path for both the interrupt and the DMA request, and the enables that belong to the result context are ignored. A result-context event exists only when the save-context flag is set and the engine reports that the operation has finished.

After reset, a short settle counter runs before a reset-done flag goes high. Until then, the interrupt and all DMA requests stay low. Every output, including the read data, is registered, so each one follows its inputs one clock edge later.

Top module: `crypto_irq_dma_map`

## Requirements
- R1: While `rst` is high and after it falls, `irq`, all four DMA requests and `reg_rdata` are 0, and the interrupt enable word and the configuration word read back as 0.
- R2: Word 3 bit 0 (reset done) becomes 1 at the SETTLE-th rising edge after reset is released and then stays 1. Until the edge after it becomes 1, `irq` and every DMA request stay 0 whatever the events and enables are.
- R3: Word 0 bits [3:0] show the live events one edge after they are presented: bit 0 context-in, bit 1 data-in, bit 2 data-out, bit 3 context-out. Each bit clears one edge after its condition drops.
- R4: The context-out event is `op_done AND save_ctx`. An `op_done` without `save_ctx` sets no status bit, interrupt or request.
- R5: Word 1 bits [3:0] are interrupt enables with the same layout as word 0, and all are 0 after reset. `irq` is the registered OR of the events whose enable is 1.
- R6: Word 2 holds the DMA enables: bit 5 data-in, bit 6 data-out, bit 7 context-in, bit 8 context-out. Each request is high one edge after its event and its enable are both 1, and falls one edge after either drops.
- R7: When word 2 bit 9 (fold) is 1, the context-out event drives `dma_data_out_req` (gated by bit 6) and the data-out interrupt term (gated by word 1 bit 2). `dma_ctx_out_req` stays 0, and word 1 bit 3 and word 2 bit 8 have no effect.
- R8: `reg_rdata` returns the word selected by `reg_addr` one edge later, with unused bits 0. Writes to words 0 and 3, or to any address with a bit above bit 1 set, change nothing. An address with a bit above bit 1 set reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | AW (4) | Word address |
| reg_wdata | input | DW (32) | Write data |
| reg_rdata | output | DW (32) | Registered read data for `reg_addr` |
| ev_ctx_in | input | 1 | Engine can accept a new context |
| ev_data_in | input | 1 | Input buffer can take a block |
| ev_data_out | input | 1 | Output block available |
| op_done | input | 1 | Operation finished |
| save_ctx | input | 1 | Save-context flag of the current context |
| irq | output | 1 | Interrupt line |
| dma_ctx_in_req | output | 1 | DMA request, context in |
| dma_data_in_req | output | 1 | DMA request, data in |
| dma_data_out_req | output | 1 | DMA request, data out (also context out when folded) |
| dma_ctx_out_req | output | 1 | DMA request, context out |

## Verification
A register write that changes an enable word or the fold bit can land on the same edge as an event change. The outputs from that edge must still use the old enables, and the new ones take effect on the next edge. The random phase writes words 1 and 2 at random while the events toggle every cycle, with fold turned on and off. A model updates its copy of the registers only after it has computed the expected outputs, so every such collision is judged against that ordering. Directed cases also raise all events during the reset settle window, while the enables are being written, to show that the enables are accepted but nothing fires before reset done.

// File: rtl/crypto_map_pkg.sv
package crypto_map_pkg;
  localparam int NSRC = 4;
  // source indices, shared by status, interrupt enable and DMA lanes
  localparam int SRC_CTX_IN   = 0;
  localparam int SRC_DATA_IN  = 1;
  localparam int SRC_DATA_OUT = 2;
  localparam int SRC_CTX_OUT  = 3;
  // configuration word bit positions
  localparam int CFG_DMA_DATA_IN  = 5;
  localparam int CFG_DMA_DATA_OUT = 6;
  localparam int CFG_DMA_CTX_IN   = 7;
  localparam int CFG_DMA_CTX_OUT  = 8;
  localparam int CFG_FOLD         = 9;
  localparam int SYS_DONE_BIT     = 0;

  typedef enum logic [1:0] {
    WORD_STATUS = 2'd0,
    WORD_IRQ_EN = 2'd1,
    WORD_CONFIG = 2'd2,
    WORD_SYS    = 2'd3
  } word_e;

  typedef struct packed {
    logic            fold;
    logic [NSRC-1:0] dma_en;   // indexed by source
  } cfg_t;
endpackage

// File: rtl/cm_reset_seq.sv
module cm_reset_seq #(
  parameter int SETTLE = 4
) (
  input  logic clk,
  input  logic rst,
  output logic done
);
  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      cnt  <= cnt + 1'b1;
      done <= (cnt == LAST);
    end
  end
endmodule

// File: rtl/cm_regfile.sv
module cm_regfile
  import crypto_map_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [NSRC-1:0] status,
  input  logic            done,
  output logic [NSRC-1:0] ien,
  output cfg_t            cfg,
  output logic [DW-1:0]   rdata
);
  logic  hit;
  word_e sel;
  logic [DW-1:0] rd_nx;

  assign sel = word_e'(addr[1:0]);

  generate
    if (AW > 2) begin : g_hi
      assign hit = (addr[AW-1:2] == '0);
    end else begin : g_nohi
      assign hit = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ien <= '0;
      cfg <= '0;
    end else if (wr && hit) begin
      case (sel)
        WORD_IRQ_EN: ien <= wdata[NSRC-1:0];
        WORD_CONFIG: begin
          cfg.dma_en[SRC_DATA_IN]  <= wdata[CFG_DMA_DATA_IN];
          cfg.dma_en[SRC_DATA_OUT] <= wdata[CFG_DMA_DATA_OUT];
          cfg.dma_en[SRC_CTX_IN]   <= wdata[CFG_DMA_CTX_IN];
          cfg.dma_en[SRC_CTX_OUT]  <= wdata[CFG_DMA_CTX_OUT];
          cfg.fold                 <= wdata[CFG_FOLD];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_nx = '0;
    if (hit) begin
      case (sel)
        WORD_STATUS: rd_nx[NSRC-1:0] = status;
        WORD_IRQ_EN: rd_nx[NSRC-1:0] = ien;
        WORD_CONFIG: begin
          rd_nx[CFG_DMA_DATA_IN]  = cfg.dma_en[SRC_DATA_IN];
          rd_nx[CFG_DMA_DATA_OUT] = cfg.dma_en[SRC_DATA_OUT];
          rd_nx[CFG_DMA_CTX_IN]   = cfg.dma_en[SRC_CTX_IN];
          rd_nx[CFG_DMA_CTX_OUT]  = cfg.dma_en[SRC_CTX_OUT];
          rd_nx[CFG_FOLD]         = cfg.fold;
        end
        default: rd_nx[SYS_DONE_BIT] = done;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_nx;
  end
endmodule

// File: rtl/cm_event_route.sv
module cm_event_route
  import crypto_map_pkg::*;
(
  input  logic [NSRC-1:0] ev,
  input  logic [NSRC-1:0] ien,
  input  cfg_t            cfg,
  input  logic            done,
  output logic            irq_nx,
  output logic [NSRC-1:0] dma_nx
);
  logic [NSRC-1:0] eff;

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_lane
      if (i == SRC_DATA_OUT) begin : g_dout
        assign eff[i] = ev[i] | (cfg.fold & ev[SRC_CTX_OUT]);
      end else if (i == SRC_CTX_OUT) begin : g_cout
        assign eff[i] = ev[i] & ~cfg.fold;
      end else begin : g_plain
        assign eff[i] = ev[i];
      end
      assign dma_nx[i] = done & cfg.dma_en[i] & eff[i];
    end
  endgenerate

  assign irq_nx = done & (|(eff & ien));
endmodule

// File: rtl/crypto_irq_dma_map.sv
module crypto_irq_dma_map
  import crypto_map_pkg::*;
#(
  parameter int DW     = 32,
  parameter int AW     = 4,
  parameter int SETTLE = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          ev_ctx_in,
  input  logic          ev_data_in,
  input  logic          ev_data_out,
  input  logic          op_done,
  input  logic          save_ctx,
  output logic          irq,
  output logic          dma_ctx_in_req,
  output logic          dma_data_in_req,
  output logic          dma_data_out_req,
  output logic          dma_ctx_out_req
);
  logic [NSRC-1:0] ev_now;
  logic [NSRC-1:0] status_q;
  logic [NSRC-1:0] ien;
  cfg_t            cfg;
  logic            rst_done;
  logic            cfg_fold;
  logic            irq_nx;
  logic [NSRC-1:0] dma_nx;
  logic [NSRC-1:0] dma_q;
  logic            irq_q;

  assign ev_now[SRC_CTX_IN]   = ev_ctx_in;
  assign ev_now[SRC_DATA_IN]  = ev_data_in;
  assign ev_now[SRC_DATA_OUT] = ev_data_out;
  assign ev_now[SRC_CTX_OUT]  = op_done & save_ctx;
  assign cfg_fold             = cfg.fold;

  cm_reset_seq #(.SETTLE(SETTLE)) u_seq (
    .clk (clk),
    .rst (rst),
    .done(rst_done)
  );

  cm_regfile #(.DW(DW), .AW(AW)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr    (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .status(status_q),
    .done  (rst_done),
    .ien   (ien),
    .cfg   (cfg),
    .rdata (reg_rdata)
  );

  cm_event_route u_route (
    .ev    (ev_now),
    .ien   (ien),
    .cfg   (cfg),
    .done  (rst_done),
    .irq_nx(irq_nx),
    .dma_nx(dma_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      dma_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= ev_now;
      dma_q    <= dma_nx;
      irq_q    <= irq_nx;
    end
  end

  assign irq              = irq_q;
  assign dma_ctx_in_req   = dma_q[SRC_CTX_IN];
  assign dma_data_in_req  = dma_q[SRC_DATA_IN];
  assign dma_data_out_req = dma_q[SRC_DATA_OUT];
  assign dma_ctx_out_req  = dma_q[SRC_CTX_OUT];
endmodule

// File: rtl/crypto_map_chk.sv
module crypto_map_chk (
  input logic       clk,
  input logic       rst,
  input logic       done,
  input logic       fold,
  input logic       ev_data_in,
  input logic       op_done,
  input logic       save_ctx,
  input logic [3:0] ien,
  input logic       irq,
  input logic [3:0] dma
);
  AST_QUIET_BEFORE_READY: assert property (@(posedge clk) disable iff (rst)
    !$past(done) |-> (!irq && dma == 4'b0));                         // R2
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> done);                                                  // R2
  AST_DATA_IN_CAUSE: assert property (@(posedge clk) disable iff (rst)
    dma[1] |-> $past(ev_data_in));                                   // R6
  AST_CTXOUT_NEEDS_SAVE: assert property (@(posedge clk) disable iff (rst)
    dma[3] |-> $past(op_done && save_ctx));                          // R4
  AST_FOLD_BLOCKS_CTXOUT: assert property (@(posedge clk) disable iff (rst)
    dma[3] |-> !$past(fold));                                        // R7
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(ien) != 4'b0));                                   // R5
endmodule

bind crypto_irq_dma_map crypto_map_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .done      (rst_done),
  .fold      (cfg_fold),
  .ev_data_in(ev_data_in),
  .op_done   (op_done),
  .save_ctx  (save_ctx),
  .ien       (ien),
  .irq       (irq),
  .dma       (dma_q)
);

// File: tb/test_crypto_irq_dma_map.sv
module test_crypto_irq_dma_map;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int SETTLE = 4;
  localparam time CLK_P = 20ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic ev_ctx_in = 0, ev_data_in = 0, ev_data_out = 0, op_done = 0, save_ctx = 0;
  logic irq, dma_ctx_in_req, dma_data_in_req, dma_data_out_req, dma_ctx_out_req;

  int checks = 0;
  int failures = 0;

  // bench model state
  logic [3:0] m_ien;
  logic [9:0] m_cfg;
  logic       m_done;
  int         m_cnt;
  logic [3:0] m_prev_ev;

  always #(CLK_P/2) clk = ~clk;

  crypto_irq_dma_map #(.DW(DW), .AW(AW), .SETTLE(SETTLE)) i_crypto_irq_dma_map (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_ctx_in(ev_ctx_in), .ev_data_in(ev_data_in), .ev_data_out(ev_data_out),
    .op_done(op_done), .save_ctx(save_ctx), .irq(irq),
    .dma_ctx_in_req(dma_ctx_in_req), .dma_data_in_req(dma_data_in_req),
    .dma_data_out_req(dma_data_out_req), .dma_ctx_out_req(dma_ctx_out_req)
  );

  // {irq, ctx_out, data_out, data_in, ctx_in}
  function automatic logic [4:0] exp_out(logic [3:0] ev, logic [3:0] ien,
                                         logic [9:0] cfg, logic done);
    logic [3:0] eff, en;
    eff = ev;
    if (cfg[9]) begin
      eff[2] = ev[2] | ev[3];
      eff[3] = 1'b0;
    end
    en = {cfg[8], cfg[6], cfg[5], cfg[7]};
    return done ? {|(eff & ien), eff & en} : 5'b0;
  endfunction

  function automatic logic [31:0] exp_rd(logic [AW-1:0] a, logic [3:0] prev_ev,
                                         logic [3:0] ien, logic [9:0] cfg, logic done);
    if (a[AW-1:2] != '0) return 32'b0;
    case (a[1:0])
      2'd0: return {28'b0, prev_ev};
      2'd1: return {28'b0, ien};
      2'd2: return {22'b0, cfg[9:5], 5'b0};
      default: return {31'b0, done};
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, check at the following negedge
  task automatic step(string tag, logic [4:0] evs, logic wr, logic [AW-1:0] a,
                      logic [31:0] wd);
    logic [3:0] ev;
    logic [4:0] eo;
    logic [31:0] er;
    {save_ctx, op_done, ev_data_out, ev_data_in, ev_ctx_in} = evs;
    reg_wr = wr; reg_addr = a; reg_wdata = wd;
    ev = {evs[3] & evs[4], evs[2:0]};
    eo = exp_out(ev, m_ien, m_cfg, m_done);
    er = exp_rd(a, m_prev_ev, m_ien, m_cfg, m_done);
    if (wr && a[AW-1:2] == '0) begin
      if (a[1:0] == 2'd1) m_ien = wd[3:0];
      if (a[1:0] == 2'd2) m_cfg = {wd[9:5], 5'b0};
    end
    if (!m_done) begin
      m_done = (m_cnt == SETTLE - 1);
      m_cnt++;
    end
    m_prev_ev = ev;
    @(negedge clk);
    check(tag, "outputs", {27'b0, irq, dma_ctx_out_req, dma_data_out_req,
                           dma_data_in_req, dma_ctx_in_req}, {27'b0, eo});
    check(tag, "rdata", reg_rdata, er);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    {save_ctx, op_done, ev_data_out, ev_data_in, ev_ctx_in} = 5'b11111;
    reg_wr = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "irq/dma in reset", {27'b0, irq, dma_ctx_out_req, dma_data_out_req,
                                     dma_data_in_req, dma_ctx_in_req}, 32'b0);
    check("R1", "rdata in reset", reg_rdata, 32'b0);
    rst = 1'b0;
    m_ien = '0; m_cfg = '0; m_done = 1'b0; m_cnt = 0; m_prev_ev = '0;
  endtask

  initial begin
    #(CLK_P * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    @(negedge clk);
    do_reset();
    // R1: enables read back zero after reset
    step("R1", 5'b00000, 0, 4'd1, 0);
    step("R1", 5'b00000, 0, 4'd2, 0);
    // R2: events all high and enables written during the settle window
    do_reset();
    step("R2", 5'b11111, 1, 4'd1, 32'hF);
    step("R2", 5'b11111, 1, 4'd2, 32'h1E0);
    for (int i = 0; i < 5; i++) step("R2", 5'b11111, 0, 4'd3, 0);
    // R3: status follows and clears
    step("R3", 5'b00001, 0, 4'd0, 0);
    step("R3", 5'b00010, 0, 4'd0, 0);
    step("R3", 5'b00100, 0, 4'd0, 0);
    step("R3", 5'b11000, 0, 4'd0, 0);
    step("R3", 5'b00000, 0, 4'd0, 0);
    step("R3", 5'b00000, 0, 4'd0, 0);
    // R4: op_done alone is no context-out event
    step("R4", 5'b01000, 0, 4'd0, 0);
    step("R4", 5'b01000, 0, 4'd0, 0);
    step("R4", 5'b10000, 0, 4'd0, 0);
    step("R4", 5'b11000, 0, 4'd0, 0);
    // R5: each interrupt enable on its own
    for (int b = 0; b < 4; b++) begin
      step("R5", 5'b00000, 1, 4'd1, 32'(1 << b));
      step("R5", 5'b11111, 0, 4'd1, 0);
      step("R5", 5'b00000, 0, 4'd1, 0);
      step("R5", (b == 3) ? 5'b10111 : 5'b11111 & ~(5'(1) << b), 0, 4'd1, 0);
    end
    // R6: single DMA enable, request drops when condition clears
    step("R6", 5'b00000, 1, 4'd2, 32'h040);
    step("R6", 5'b00100, 0, 4'd2, 0);
    step("R6", 5'b00000, 0, 4'd2, 0);
    step("R6", 5'b00100, 1, 4'd2, 32'h020);
    step("R6", 5'b00010, 0, 4'd2, 0);
    step("R6", 5'b00000, 0, 4'd2, 0);
    // R7: fold reroutes context-out, own enables ignored
    step("R7", 5'b00000, 1, 4'd2, 32'h300);
    step("R7", 5'b00000, 1, 4'd1, 32'h8);
    step("R7", 5'b11000, 0, 4'd2, 0);
    step("R7", 5'b11000, 1, 4'd2, 32'h340);
    step("R7", 5'b11000, 1, 4'd1, 32'h4);
    step("R7", 5'b11000, 0, 4'd1, 0);
    step("R7", 5'b00000, 0, 4'd1, 0);
    // R8: writes to read-only words and out-of-range addresses ignored
    step("R8", 5'b00101, 1, 4'd0, 32'hFFFF_FFFF);
    step("R8", 5'b00000, 1, 4'd3, 32'hFFFF_FFFF);
    step("R8", 5'b00000, 1, 4'd5, 32'hFFFF_FFFF);
    step("R8", 5'b00000, 1, 4'd6, 32'hFFFF_FFFF);
    step("R8", 5'b00000, 0, 4'd1, 0);
    step("R8", 5'b00000, 0, 4'd2, 0);
    step("R8", 5'b00000, 0, 4'd9, 0);
    // random mix: writes colliding with event changes (R5 R6 R7 R3)
    for (int n = 0; n < 3000; n++) begin
      logic wr;
      logic [AW-1:0] a;
      wr = ($urandom % 4) == 0;
      a  = AW'($urandom % 5);
      step("R5 R6 R7 R3", 5'($urandom), wr, a, $urandom);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule